// File: doc/BRIEF.md
# Floating Add/Subtract Unit

This block is a sequential adder for 48-bit floating words. It takes an accumulator word and an operand word and produces their sum or difference as a new accumulator word. A one-cycle `start` pulse launches an operation. `busy` stays high while the unit works, and a one-cycle `done` pulse marks the cycle in which the result appears. The result is then held until the next operation completes.

The work is spread over several cycles. The operand with the smaller exponent is shifted right one bit per cycle until the two exponents match, and the last bit shifted out is kept as a guard bit. The signed fractions are then added. If the sum is out of range, it is shifted right once and the exponent is raised by one. Unless suppressed by an option, the result is then normalized one left shift per cycle and rounded using the guard bit. A result that lands at the smallest exponent or below is cleared. The overflow flag collects exponent overflow and any flag already carried by the inputs.

Top module: `fpadd_unit`

## Requirements
- R1: Word layout: bit 47 is the overflow flag, bits 46:38 hold the exponent stored as true exponent + 256 (stored 0 means -256), and bits 37:0 hold a two's complement fraction with the binary point just right of bit 37. With `op_sub`=0 the result is acc + opnd.
- R2: With `op_sub`=1 the result is acc - opnd, or opnd - acc when `opt_reverse`=1. `opt_reverse` has no effect when `op_sub`=0.
- R3: Operands with unequal exponents are aligned by shifting the fraction with the smaller exponent right one bit per cycle, raising its exponent by one each time. The last bit shifted out is kept as a guard bit.
- R4: A sum outside the fraction range is corrected by an arithmetic right shift of one place and an exponent increment.
- R5: With `opt_unnorm`=0 the result is shifted left one place per cycle, lowering its exponent by one each time, until fraction bit 37 differs from bit 36 or the stored exponent reaches 0. Unnormalized operands are accepted.
- R6: With `opt_unnorm`=1 no normalizing shift is made.
- R7: With `opt_unround`=0 and the guard bit set, one is added at fraction bit 0, followed by a fresh overflow correction as in R4. With `opt_unround`=1 no rounding is done.
- R8: If the final stored exponent is 0 or below, bits 46:0 of the result are zero, and bit 47 still follows R9.
- R9: Result bit 47 (also on `res_ovf`) is set when the final stored exponent exceeds 511, in which case the exponent field keeps its low 9 bits. It is also set when bit 47 of either input word was set.
- R10: `start` is taken only while `busy` is low. `busy` stays high from the cycle after the start until `done`, and `start` while busy is ignored. `done` is a single-cycle pulse, and the result changes only in that cycle.
- R11: Synchronous active-high `rst` clears `busy`, `done`, `res_word` and `res_ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation when idle |
| op_sub | input | 1 | 0 add, 1 subtract |
| opt_unround | input | 1 | Skip rounding |
| opt_unnorm | input | 1 | Skip normalization |
| opt_reverse | input | 1 | Subtract in reverse order (opnd - acc) |
| acc_word | input | 48 | Accumulator operand word |
| opnd_word | input | 48 | Second operand word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| res_word | output | 48 | Result word |
| res_ovf | output | 1 | Overflow flag of the result |

## Verification
On every cycle the assertions check the handshake: `done` lasts one cycle, `busy` is low when it fires, and the result is stable between completions. They also check the datapath stages. Exponents must be equal when the addition happens. A normalized fraction must leave the shift loop unless the exponent floor was reached. The underflow clear and the flag carry-through must show up on the result word. The actual arithmetic values can only be shown by the bench's scenarios, each with hand-worked results: the sum and difference, the reversed order, the alignment guard feeding the rounding, the range correction, exponent overflow and underflow clearing, and the ignored inputs.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ALIGN,
    S_CORR,
    S_NORM,
    S_ROUND,
    S_FIN
  } fa_state_t;
endpackage

// File: rtl/fpadd_unpack.sv
// Splits a word into a widened signed fraction (extra sign bit on top, guard bit
// at the bottom), a signed stored exponent and the flag; optionally negates.
module fpadd_unpack #(
  parameter int FW = 38,
  parameter int EW = 9,
  localparam int W  = FW + 2,
  localparam int XW = EW + 2
) (
  input  logic [FW+EW:0]        word,
  input  logic                  negate,
  output logic signed [W-1:0]   frac,
  output logic signed [XW-1:0]  expo,
  output logic                  flag
);
  logic signed [W-1:0] ext;
  always_comb begin
    ext  = {word[FW-1], word[FW-1:0], 1'b0};
    frac = negate ? -ext : ext;
    expo = $signed({2'b00, word[FW+EW-1:FW]});
    flag = word[FW+EW];
  end
endmodule

// File: rtl/fpadd_ovfix.sv
// Range correction: when the two top bits disagree the sum left the fraction
// range, so shift right once and bump the exponent.
module fpadd_ovfix #(
  parameter int W  = 40,
  parameter int XW = 11
) (
  input  logic signed [W-1:0]  f_in,
  input  logic signed [XW-1:0] e_in,
  output logic signed [W-1:0]  f_out,
  output logic signed [XW-1:0] e_out
);
  localparam logic signed [XW-1:0] ONE = XW'(1);
  always_comb begin
    if (f_in[W-1] != f_in[W-2]) begin
      f_out = f_in >>> 1;
      e_out = e_in + ONE;
    end else begin
      f_out = f_in;
      e_out = e_in;
    end
  end
endmodule

// File: rtl/fpadd_pack.sv
// Final correction, underflow clear, overflow flag and word assembly.
module fpadd_pack #(
  parameter int FW = 38,
  parameter int EW = 9,
  localparam int W  = FW + 2,
  localparam int XW = EW + 2
) (
  input  logic signed [W-1:0]  frac_in,
  input  logic signed [XW-1:0] exp_in,
  input  logic                 flag_in,
  output logic [FW+EW:0]       word,
  output logic                 uflow
);
  localparam logic signed [XW-1:0] EMAX_S = XW'((1 << EW) - 1);

  logic signed [W-1:0]  fx;
  logic signed [XW-1:0] ex;
  logic                 eover, flag;
  logic                 unused_edge;

  fpadd_ovfix #(.W(W), .XW(XW)) u_fix (
    .f_in(frac_in), .e_in(exp_in), .f_out(fx), .e_out(ex)
  );

  assign unused_edge = ^{fx[W-1], fx[0]};

  always_comb begin
    uflow = ex[XW-1] || (ex == '0);
    eover = !ex[XW-1] && (ex > EMAX_S);
    flag  = flag_in | eover;
    if (uflow) word = {flag, {(FW+EW){1'b0}}};
    else       word = {flag, ex[EW-1:0], fx[W-2:1]};
  end
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
  import fpadd_pkg::*;
#(
  parameter int FW = 38,
  parameter int EW = 9,
  localparam int W  = FW + 2,
  localparam int XW = EW + 2,
  localparam int WD = FW + EW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_sub,
  input  logic          opt_unround,
  input  logic          opt_unnorm,
  input  logic          opt_reverse,
  input  logic [WD-1:0] acc_word,
  input  logic [WD-1:0] opnd_word,
  output logic          busy,
  output logic          done,
  output logic [WD-1:0] res_word,
  output logic          res_ovf
);
  localparam logic signed [XW-1:0] ONE = XW'(1);
  localparam logic signed [W-1:0]  ULP = W'(2);

  fa_state_t state;
  logic signed [W-1:0]  fa, fb;
  logic signed [XW-1:0] ea, eb;
  logic flag_r, unround_r, unnorm_r;

  logic signed [W-1:0]  ua_f, ub_f, cx_f;
  logic signed [XW-1:0] ua_e, ub_e, cx_e;
  logic ua_fl, ub_fl;
  logic [WD-1:0] pk_word;
  logic pk_uflow;
  logic is_norm, e_floor;

  fpadd_unpack #(.FW(FW), .EW(EW)) u_unpack_a (
    .word(acc_word), .negate(op_sub & opt_reverse),
    .frac(ua_f), .expo(ua_e), .flag(ua_fl)
  );
  fpadd_unpack #(.FW(FW), .EW(EW)) u_unpack_b (
    .word(opnd_word), .negate(op_sub & ~opt_reverse),
    .frac(ub_f), .expo(ub_e), .flag(ub_fl)
  );
  fpadd_ovfix #(.W(W), .XW(XW)) u_corr (
    .f_in(fa), .e_in(ea), .f_out(cx_f), .e_out(cx_e)
  );
  fpadd_pack #(.FW(FW), .EW(EW)) u_pack (
    .frac_in(fa), .exp_in(ea), .flag_in(flag_r),
    .word(pk_word), .uflow(pk_uflow)
  );

  assign busy    = (state != S_IDLE);
  assign is_norm = (fa[W-2] != fa[W-3]);
  assign e_floor = ea[XW-1] || (ea == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fa        <= '0;
      fb        <= '0;
      ea        <= '0;
      eb        <= '0;
      flag_r    <= 1'b0;
      unround_r <= 1'b0;
      unnorm_r  <= 1'b0;
      done      <= 1'b0;
      res_word  <= '0;
      res_ovf   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fa        <= ua_f;
          fb        <= ub_f;
          ea        <= ua_e;
          eb        <= ub_e;
          flag_r    <= ua_fl | ub_fl;
          unround_r <= opt_unround;
          unnorm_r  <= opt_unnorm;
          state     <= S_ALIGN;
        end
        S_ALIGN: begin
          if (ea < eb) begin
            fa <= fa >>> 1;
            ea <= ea + ONE;
          end else if (eb < ea) begin
            fb <= fb >>> 1;
            eb <= eb + ONE;
          end else begin
            fa    <= fa + fb;
            state <= S_CORR;
          end
        end
        S_CORR: begin
          fa    <= cx_f;
          ea    <= cx_e;
          state <= unnorm_r ? S_ROUND : S_NORM;
        end
        S_NORM: begin
          if (is_norm || e_floor) begin
            state <= S_ROUND;
          end else begin
            fa <= fa <<< 1;
            ea <= ea - ONE;
          end
        end
        S_ROUND: begin
          if (!unround_r && fa[0]) fa <= fa + ULP;
          state <= S_FIN;
        end
        S_FIN: begin
          res_word <= pk_word;
          res_ovf  <= pk_word[WD-1];
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse with the unit idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10: result only moves on completion
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_word) && $stable(res_ovf)));
  // R3: fractions are summed only with equal exponents
  a_r3_aligned_sum: assert property (@(posedge clk) disable iff (rst)
    (state == S_CORR) |-> ($past(ea) == $past(eb)));
  // R5: normalization leaves with a normalized fraction unless at the floor
  a_r5_norm_exit: assert property (@(posedge clk) disable iff (rst)
    (state == S_ROUND && !unnorm_r && !e_floor) |-> is_norm);
  // R8: underflow clears fraction and exponent of the result
  a_r8_uflow_clear: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIN && pk_uflow) |=> (res_word[WD-2:0] == '0));
  // R9: an incoming flag reaches the result
  a_r9_flag_carry: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIN && flag_r) |=> res_ovf);
endmodule

// File: tb/fpadd_unit_bench.sv
module fpadd_unit_bench;
  localparam int FW = 38;
  localparam int EW = 9;
  localparam int WD = FW + EW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_sub = 1'b0, opt_unround = 1'b0, opt_unnorm = 1'b0, opt_reverse = 1'b0;
  logic [WD-1:0] acc_word = '0, opnd_word = '0;
  logic busy, done, res_ovf;
  logic [WD-1:0] res_word;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpadd_unit #(.FW(FW), .EW(EW)) u_fpadd_unit (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .opt_unround(opt_unround), .opt_unnorm(opt_unnorm), .opt_reverse(opt_reverse),
    .acc_word(acc_word), .opnd_word(opnd_word),
    .busy(busy), .done(done), .res_word(res_word), .res_ovf(res_ovf)
  );

  function automatic logic [WD-1:0] mk(input logic fl, input int ex, input logic [FW-1:0] fr);
    return {fl, ex[EW-1:0], fr};
  endfunction

  localparam logic [FW-1:0] F_HALF = FW'(1) << 36;
  localparam logic [FW-1:0] F_QTR  = FW'(1) << 35;
  localparam logic [FW-1:0] F_3Q   = FW'(3) << 35;
  localparam logic [FW-1:0] F_8TH  = FW'(1) << 34;
  localparam logic [FW-1:0] F_5_8  = FW'(5) << 34;
  localparam logic [FW-1:0] F_NEG1 = FW'(1) << 37;

  task automatic chk(input string tag, input logic [WD-1:0] got, input logic [WD-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int cnt = 0;
    while (!done && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s: got no done expected done within 3000 cycles", tag);
    end
  endtask

  task automatic run_op(input logic [WD-1:0] a, input logic [WD-1:0] b,
                        input logic sub, input logic ur, input logic un, input logic rv,
                        input string tag, output logic [WD-1:0] res);
    @(negedge clk);
    acc_word = a; opnd_word = b; op_sub = sub;
    opt_unround = ur; opt_unnorm = un; opt_reverse = rv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tag);
    res = res_word;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 busy", {47'b0, busy}, '0);
    chk("R11 done", {47'b0, done}, '0);
    chk("R11 result", res_word, '0);
    chk("R11 flag", {47'b0, res_ovf}, '0);
  endtask

  task automatic t_add();
    logic [WD-1:0] r;
    run_op(mk(0, 257, F_HALF), mk(0, 257, F_QTR), 0, 0, 0, 0, "R1", r);
    chk("R1 0.5+0.25", r, mk(0, 257, F_3Q));
  endtask

  task automatic t_range_fix();
    logic [WD-1:0] r;
    run_op(mk(0, 257, F_HALF), mk(0, 257, F_HALF), 0, 0, 0, 0, "R4", r);
    chk("R4 0.5+0.5 corrected", r, mk(0, 258, F_HALF));
  endtask

  task automatic t_sub();
    logic [WD-1:0] r;
    run_op(mk(0, 257, F_3Q), mk(0, 257, F_HALF), 1, 0, 0, 0, "R2", r);
    chk("R2/R5 0.75-0.5 normalized", r, mk(0, 256, F_HALF));
    run_op(mk(0, 257, F_3Q), mk(0, 257, F_HALF), 1, 0, 1, 0, "R6", r);
    chk("R6 unnormalized difference", r, mk(0, 257, F_QTR));
  endtask

  task automatic t_reverse();
    logic [WD-1:0] r;
    run_op(mk(0, 257, F_3Q), mk(0, 257, F_HALF), 1, 0, 0, 1, "R2", r);
    chk("R2 reversed 0.5-0.75", r, mk(0, 255, F_NEG1));
    run_op(mk(0, 257, F_3Q), mk(0, 257, F_HALF), 0, 0, 0, 1, "R2", r);
    chk("R2 reverse ignored on add", r, mk(0, 258, F_5_8));
  endtask

  task automatic t_align_round();
    logic [WD-1:0] r;
    run_op(mk(0, 257, F_HALF), mk(0, 256, FW'(1)), 0, 0, 0, 0, "R7", r);
    chk("R3/R7 guard rounds up", r, mk(0, 257, F_HALF + FW'(1)));
    run_op(mk(0, 257, F_HALF), mk(0, 256, FW'(1)), 0, 1, 0, 0, "R7", r);
    chk("R7 unrounded", r, mk(0, 257, F_HALF));
  endtask

  task automatic t_unnorm_in();
    logic [WD-1:0] r;
    run_op(mk(0, 258, F_8TH), mk(0, 258, F_8TH), 0, 0, 0, 0, "R5", r);
    chk("R5 unnormalized inputs", r, mk(0, 257, F_HALF));
  endtask

  task automatic t_underflow();
    logic [WD-1:0] r;
    run_op(mk(0, 1, F_HALF), mk(0, 1, F_QTR), 1, 0, 0, 0, "R8", r);
    chk("R8 underflow clears", r, '0);
    run_op(mk(1, 1, F_HALF), mk(0, 1, F_QTR), 1, 0, 0, 0, "R8", r);
    chk("R8 underflow keeps flag", r, mk(1, 0, '0));
    run_op(mk(0, 257, F_HALF), mk(0, 257, F_HALF), 1, 0, 0, 0, "R8", r);
    chk("R8 zero difference clears", r, '0);
  endtask

  task automatic t_overflow();
    logic [WD-1:0] r;
    run_op(mk(0, 511, F_HALF), mk(0, 511, F_HALF), 0, 0, 0, 0, "R9", r);
    chk("R9 exponent overflow", r, mk(1, 0, F_HALF));
    chk("R9 flag pin", {47'b0, res_ovf}, 48'd1);
    run_op(mk(0, 257, F_HALF), mk(1, 257, F_QTR), 0, 0, 0, 0, "R9", r);
    chk("R9 operand flag carried", r, mk(1, 257, F_3Q));
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    acc_word = mk(0, 257, F_HALF); opnd_word = mk(0, 257, F_QTR);
    op_sub = 0; opt_unround = 0; opt_unnorm = 0; opt_reverse = 0;
    start = 1'b1;
    @(negedge clk);
    chk("R10 busy after start", {47'b0, busy}, 48'd1);
    acc_word = mk(0, 300, F_3Q); opnd_word = mk(0, 300, F_3Q); op_sub = 1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    chk("R10 start while busy ignored", res_word, mk(0, 257, F_3Q));
    @(negedge clk);
    chk("R10 done is one cycle", {47'b0, done}, '0);
    chk("R10 result held", res_word, mk(0, 257, F_3Q));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_range_fix();
    t_sub();
    t_reverse();
    t_align_round();
    t_unnorm_in();
    t_underflow();
    t_overflow();
    t_busy_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule